// File: doc/BRIEF.md
# Undocumented Opcode Execution Unit

This block carries out the undocumented instructions of an 8-bit accumulator CPU. The core's address path resolves the operand and gives it to the unit, along with the register file values (A, X, Y, S), the incoming N, Z and C flags, and the high byte of the base address. At the start strobe the unit decodes the opcode and computes the new register values. It also computes a memory write byte and the flag results. All of these results are latched and held.

A small cycle sequencer then counts the bus cycles that the opcode and its addressing mode require. A page-crossing input adds one cycle for the opcodes that allow it. The sequencer raises a one-cycle `done` pulse on the last counted cycle, and the memory write enable is asserted in that same cycle. The unit also reports which addressing-mode timing it applied.

An opcode that is not in the supported set changes nothing. It raises a one-cycle `unsupported` pulse instead.

Top module: `undoc_exec`

## Requirements
- R1: LAX ($A7 zp, $B7 zp,Y, $AF abs, $BF abs,Y, $A3 (zp,X), $B3 (zp),Y) writes the operand M to both A and X. The immediate form ($AB) writes (A OR K) AND M to both, where K is the parameter MAGIC (default 8'hEE). N and Z follow the loaded value; C passes through unchanged.
- R2: SBX ($CB) writes ((A AND X) - M) mod 256 to X. N and Z follow that value. C is 1 when (A AND X) >= M unsigned.
- R3: SLO (opcodes with bits [7:5] = 000 and low five bits $07, $17, $0F, $1F, $1B, $03 or $13) writes M shifted left by one to memory and sets A = A OR that value. C takes M bit 7, and N and Z follow the new A.
- R4: SRE (the same low five bits with bits [7:5] = 010) writes M shifted right by one to memory and sets A = A XOR that value. C takes M bit 0, and N and Z follow the new A.
- R5: LAS ($BB) writes M AND S to A, X and S. N and Z follow that value.
- R6: The masked stores leave the flags unchanged. With H1 = (high byte + 1) mod 256: SHX ($9E) writes X AND H1; SHY ($9C) writes Y AND H1; SHA ($9F, $93) writes A AND X AND H1. TAS ($9B) sets S = A AND X and writes A AND X AND H1.
- R7: XAA ($8B) sets A = (A OR K) AND X AND M. N and Z follow the new A.
- R8: `done` is high for exactly one cycle, N-1 clock edges after the edge that accepts `start`, where N is the cycle count. The counts are:
  - immediate: 2
  - LAX: zp 3, zp,Y 4, abs 4, (zp,X) 6, (zp),Y 5
  - LAS: 4
  - SLO/SRE: zp 5, zp,X 6, abs 6, abs,X 7, abs,Y 7, (zp,X) 8, (zp),Y 8
  - SHX, SHY, TAS, SHA $9F: 5
  - SHA $93: 6

  `page_cross` adds 1 only for $BF, $B3 and $BB.
- R9: `addr_mode` reports the timing applied: 0 imm, 1 zp, 2 zp,X, 3 zp,Y, 4 abs, 5 abs,X, 6 abs,Y, 7 (zp,X), 8 (zp),Y. An unsupported opcode reports 15.
- R10: An unsupported opcode returns A, X, Y, S and the flags unchanged. `unsupported` is high for the single cycle after the accepting edge. `busy`, `done` and `mem_we` stay low.
- R11: `mem_we` is high only in the `done` cycle, and only for SLO, SRE, SHX, SHY, SHA and TAS. `mem_wdata` carries the byte given in R3, R4 and R6.
- R12: A `start` while `busy` is ignored. The outputs and the running count are not disturbed.
- R13: After reset, all data outputs and flags are 0, `addr_mode` is 15, and `busy`, `done`, `mem_we` and `unsupported` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept the presented instruction when idle |
| opcode | input | 8 | Opcode byte |
| reg_a | input | 8 | Current accumulator |
| reg_x | input | 8 | Current X index |
| reg_y | input | 8 | Current Y index |
| reg_s | input | 8 | Current stack pointer |
| operand | input | 8 | Resolved memory operand M |
| addr_hi | input | 8 | High byte of the base address |
| page_cross | input | 1 | Indexed access crossed a page |
| flag_n_in | input | 1 | Current N flag |
| flag_z_in | input | 1 | Current Z flag |
| flag_c_in | input | 1 | Current C flag |
| a_out | output | 8 | New accumulator |
| x_out | output | 8 | New X index |
| y_out | output | 8 | New Y index |
| s_out | output | 8 | New stack pointer |
| mem_wdata | output | 8 | Byte to write to memory |
| mem_we | output | 1 | Memory write enable, in the done cycle |
| flag_n | output | 1 | New N flag |
| flag_z | output | 1 | New Z flag |
| flag_c | output | 1 | New C flag |
| addr_mode | output | 4 | Addressing-mode timing code |
| busy | output | 1 | Cycle count in progress |
| done | output | 1 | Final cycle of the instruction |
| unsupported | output | 1 | Opcode not in the supported set |

## Verification
The checks assume that the CPU raises `start` only with its inputs valid in that same cycle. They also assume the unit ignores any later change to those inputs until the next accepted `start`, so the inputs may change freely while the unit is busy. The sequencer checks take for granted that it is loaded only when idle and only with a count between 2 and the maximum; the decoder guarantees both. The stimulus waits for `done`, or for the end of an unsupported pulse, before it presents the next opcode. It also makes one deliberate overlapping `start`. This keeps every run within these assumptions while it sweeps all 256 opcodes, several operand sets and both page-crossing values.

// File: rtl/undoc_pkg.sv
package undoc_pkg;

    localparam int DW      = 8;
    localparam int MAX_CYC = 9;
    localparam int CW      = $clog2(MAX_CYC + 1);

    typedef enum logic [3:0] {
        AM_IMM  = 4'd0,
        AM_ZP   = 4'd1,
        AM_ZPX  = 4'd2,
        AM_ZPY  = 4'd3,
        AM_ABS  = 4'd4,
        AM_ABSX = 4'd5,
        AM_ABSY = 4'd6,
        AM_INDX = 4'd7,
        AM_INDY = 4'd8,
        AM_NONE = 4'd15
    } amode_e;

    typedef enum logic [3:0] {
        K_NONE, K_LAX, K_SBX, K_SLO, K_SRE, K_LAS,
        K_SHX,  K_SHY, K_SHA, K_TAS, K_XAA
    } kind_e;

    typedef struct packed {
        kind_e          kind;
        amode_e         mode;
        logic [CW-1:0]  base;
        logic           pc_adds;
    } dec_t;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] x;
        logic [DW-1:0] y;
        logic [DW-1:0] s;
        logic [DW-1:0] wd;
        logic          we;
        logic          n;
        logic          z;
        logic          c;
    } res_t;

    // Shift-then-logic read-modify-write: timing by addressing mode
    function automatic logic [CW-1:0] rmw_cycles(input amode_e m);
        case (m)
            AM_ZP:   rmw_cycles = CW'(5);
            AM_ZPX:  rmw_cycles = CW'(6);
            AM_ABS:  rmw_cycles = CW'(6);
            AM_ABSX: rmw_cycles = CW'(7);
            AM_ABSY: rmw_cycles = CW'(7);
            default: rmw_cycles = CW'(8);
        endcase
    endfunction

endpackage

// File: rtl/undoc_decode.sv
module undoc_decode
    import undoc_pkg::*;
(
    input  logic [DW-1:0] opcode,
    output dec_t          dec
);

    logic   rmw_hit;
    amode_e rmw_mode;

    // Read-modify-write group: opcode bits [7:5] pick the logic, [4:0] the mode
    always_comb begin
        rmw_hit  = 1'b1;
        rmw_mode = AM_NONE;
        case (opcode[4:0])
            5'h07:   rmw_mode = AM_ZP;
            5'h17:   rmw_mode = AM_ZPX;
            5'h0F:   rmw_mode = AM_ABS;
            5'h1F:   rmw_mode = AM_ABSX;
            5'h1B:   rmw_mode = AM_ABSY;
            5'h03:   rmw_mode = AM_INDX;
            5'h13:   rmw_mode = AM_INDY;
            default: rmw_hit  = 1'b0;
        endcase
        if (opcode[7] || opcode[5]) begin
            rmw_hit = 1'b0;
        end
    end

    always_comb begin
        dec.kind    = K_NONE;
        dec.mode    = AM_NONE;
        dec.base    = CW'(0);
        dec.pc_adds = 1'b0;
        if (rmw_hit) begin
            dec.kind = opcode[6] ? K_SRE : K_SLO;
            dec.mode = rmw_mode;
            dec.base = rmw_cycles(rmw_mode);
        end else begin
            case (opcode)
                8'hAB: begin dec.kind = K_LAX; dec.mode = AM_IMM;  dec.base = CW'(2); end
                8'hA7: begin dec.kind = K_LAX; dec.mode = AM_ZP;   dec.base = CW'(3); end
                8'hB7: begin dec.kind = K_LAX; dec.mode = AM_ZPY;  dec.base = CW'(4); end
                8'hAF: begin dec.kind = K_LAX; dec.mode = AM_ABS;  dec.base = CW'(4); end
                8'hBF: begin dec.kind = K_LAX; dec.mode = AM_ABSY; dec.base = CW'(4); dec.pc_adds = 1'b1; end
                8'hA3: begin dec.kind = K_LAX; dec.mode = AM_INDX; dec.base = CW'(6); end
                8'hB3: begin dec.kind = K_LAX; dec.mode = AM_INDY; dec.base = CW'(5); dec.pc_adds = 1'b1; end
                8'hCB: begin dec.kind = K_SBX; dec.mode = AM_IMM;  dec.base = CW'(2); end
                8'hBB: begin dec.kind = K_LAS; dec.mode = AM_ABSY; dec.base = CW'(4); dec.pc_adds = 1'b1; end
                8'h9E: begin dec.kind = K_SHX; dec.mode = AM_ABSY; dec.base = CW'(5); end
                8'h9C: begin dec.kind = K_SHY; dec.mode = AM_ABSX; dec.base = CW'(5); end
                8'h9B: begin dec.kind = K_TAS; dec.mode = AM_ABSY; dec.base = CW'(5); end
                8'h9F: begin dec.kind = K_SHA; dec.mode = AM_ABSY; dec.base = CW'(5); end
                8'h93: begin dec.kind = K_SHA; dec.mode = AM_INDY; dec.base = CW'(6); end
                8'h8B: begin dec.kind = K_XAA; dec.mode = AM_IMM;  dec.base = CW'(2); end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/undoc_alu.sv
module undoc_alu
    import undoc_pkg::*;
#(
    parameter logic [DW-1:0] MAGIC = 8'hEE
) (
    input  kind_e         kind,
    input  amode_e        mode,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic [DW-1:0] s,
    input  logic [DW-1:0] m,
    input  logic [DW-1:0] hi,
    input  logic          n_in,
    input  logic          z_in,
    input  logic          c_in,
    output res_t          res
);

    logic [DW-1:0] hi_inc;
    logic [DW-1:0] ax;
    logic [DW-1:0] shl;
    logic [DW-1:0] shr;
    logic [DW:0]   diff;
    logic [DW-1:0] nz_src;
    logic          nz_upd;

    assign hi_inc = hi + DW'(1);
    assign ax     = a & x;
    assign shl    = {m[DW-2:0], 1'b0};
    assign shr    = {1'b0, m[DW-1:1]};
    assign diff   = {1'b0, ax} - {1'b0, m};

    always_comb begin
        res.a  = a;
        res.x  = x;
        res.y  = y;
        res.s  = s;
        res.wd = '0;
        res.we = 1'b0;
        res.c  = c_in;
        nz_src = '0;
        nz_upd = 1'b0;
        case (kind)
            K_LAX: begin
                nz_src = (mode == AM_IMM) ? ((a | MAGIC) & m) : m;
                res.a  = nz_src;
                res.x  = nz_src;
                nz_upd = 1'b1;
            end
            K_SBX: begin
                nz_src = diff[DW-1:0];
                res.x  = nz_src;
                res.c  = ~diff[DW];
                nz_upd = 1'b1;
            end
            K_SLO: begin
                res.wd = shl;
                res.we = 1'b1;
                nz_src = a | shl;
                res.a  = nz_src;
                res.c  = m[DW-1];
                nz_upd = 1'b1;
            end
            K_SRE: begin
                res.wd = shr;
                res.we = 1'b1;
                nz_src = a ^ shr;
                res.a  = nz_src;
                res.c  = m[0];
                nz_upd = 1'b1;
            end
            K_LAS: begin
                nz_src = m & s;
                res.a  = nz_src;
                res.x  = nz_src;
                res.s  = nz_src;
                nz_upd = 1'b1;
            end
            K_SHX: begin
                res.wd = x & hi_inc;
                res.we = 1'b1;
            end
            K_SHY: begin
                res.wd = y & hi_inc;
                res.we = 1'b1;
            end
            K_SHA: begin
                res.wd = ax & hi_inc;
                res.we = 1'b1;
            end
            K_TAS: begin
                res.s  = ax;
                res.wd = ax & hi_inc;
                res.we = 1'b1;
            end
            K_XAA: begin
                nz_src = (a | MAGIC) & x & m;
                res.a  = nz_src;
                nz_upd = 1'b1;
            end
            default: ;
        endcase
        res.n = nz_upd ? nz_src[DW-1]     : n_in;
        res.z = nz_upd ? (nz_src == '0)   : z_in;
    end

endmodule

// File: rtl/undoc_seq.sv
module undoc_seq
    import undoc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          busy,
    output logic          done
);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] left;
    } sq_t;

    sq_t sq_d, sq_q;

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        if (sq_q.busy) begin
            if (sq_q.left == '0) begin
                sq_d.busy = 1'b0;
                sq_d.done = 1'b1;
            end else begin
                sq_d.left = sq_q.left - CW'(1);
            end
        end else if (load) begin
            sq_d.busy = 1'b1;
            sq_d.left = len - CW'(2);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy = sq_q.busy;
    assign done = sq_q.done;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!busy && len >= CW'(2) && len <= CW'(MAX_CYC))); // R12

endmodule

// File: rtl/undoc_exec.sv
module undoc_exec
    import undoc_pkg::*;
#(
    parameter logic [DW-1:0] MAGIC = 8'hEE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] opcode,
    input  logic [DW-1:0] reg_a,
    input  logic [DW-1:0] reg_x,
    input  logic [DW-1:0] reg_y,
    input  logic [DW-1:0] reg_s,
    input  logic [DW-1:0] operand,
    input  logic [DW-1:0] addr_hi,
    input  logic          page_cross,
    input  logic          flag_n_in,
    input  logic          flag_z_in,
    input  logic          flag_c_in,
    output logic [DW-1:0] a_out,
    output logic [DW-1:0] x_out,
    output logic [DW-1:0] y_out,
    output logic [DW-1:0] s_out,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_c,
    output logic [3:0]    addr_mode,
    output logic          busy,
    output logic          done,
    output logic          unsupported
);

    typedef struct packed {
        res_t   r;
        amode_e mode;
        logic   unsup;
    } st_t;

    st_t            st_d, st_q;
    dec_t           dec;
    res_t           alu_res;
    logic           accept;
    logic           known;
    logic [CW-1:0]  run_len;

    undoc_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    undoc_alu #(.MAGIC(MAGIC)) u_alu (
        .kind (dec.kind),
        .mode (dec.mode),
        .a    (reg_a),
        .x    (reg_x),
        .y    (reg_y),
        .s    (reg_s),
        .m    (operand),
        .hi   (addr_hi),
        .n_in (flag_n_in),
        .z_in (flag_z_in),
        .c_in (flag_c_in),
        .res  (alu_res)
    );

    assign accept  = start && !busy;
    assign known   = (dec.kind != K_NONE);
    assign run_len = dec.base + CW'(dec.pc_adds & page_cross);

    undoc_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept && known),
        .len   (run_len),
        .busy  (busy),
        .done  (done)
    );

    always_comb begin
        st_d       = st_q;
        st_d.unsup = 1'b0;
        if (accept) begin
            st_d.r     = alu_res;
            st_d.mode  = dec.mode;
            st_d.unsup = !known;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= AM_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_out       = st_q.r.a;
    assign x_out       = st_q.r.x;
    assign y_out       = st_q.r.y;
    assign s_out       = st_q.r.s;
    assign mem_wdata   = st_q.r.wd;
    assign mem_we      = st_q.r.we && done;
    assign flag_n      = st_q.r.n;
    assign flag_z      = st_q.r.z;
    assign flag_c      = st_q.r.c;
    assign addr_mode   = st_q.mode;
    assign unsupported = st_q.unsup;

    AST_WE_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> done); // R11

    AST_UNSUP_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> (a_out == $past(reg_a) && x_out == $past(reg_x) &&
                         y_out == $past(reg_y) && s_out == $past(reg_s))); // R10

    AST_UNSUP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> (!busy && !done && !mem_we)); // R10

    AST_UNSUP_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> (addr_mode == 4'd15)); // R9

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(a_out) && $stable(x_out) &&
                             $stable(mem_wdata) && $stable(addr_mode))); // R12

endmodule

// File: tb/test_undoc_exec.sv
module test_undoc_exec;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] opcode = '0, reg_a = '0, reg_x = '0, reg_y = '0, reg_s = '0;
    logic [7:0] operand = '0, addr_hi = '0;
    logic       page_cross = 1'b0, flag_n_in = 1'b0, flag_z_in = 1'b0, flag_c_in = 1'b0;
    logic [7:0] a_out, x_out, y_out, s_out, mem_wdata;
    logic       mem_we, flag_n, flag_z, flag_c, busy, done, unsupported;
    logic [3:0] addr_mode;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    localparam logic [7:0] K = 8'hEE;

    undoc_exec i_undoc_exec (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y), .reg_s(reg_s),
        .operand(operand), .addr_hi(addr_hi), .page_cross(page_cross),
        .flag_n_in(flag_n_in), .flag_z_in(flag_z_in), .flag_c_in(flag_c_in),
        .a_out(a_out), .x_out(x_out), .y_out(y_out), .s_out(s_out),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .flag_n(flag_n),
        .flag_z(flag_z), .flag_c(flag_c), .addr_mode(addr_mode),
        .busy(busy), .done(done), .unsupported(unsupported)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<150000 cycles", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Independent model of the requirements
    function automatic void model(
        input  logic [7:0] op, a, x, y, s, m, h,
        input  logic n, z, c, pc,
        output logic [7:0] ea, ex, ey, es, ewd,
        output logic ewr, en, ez, ec,
        output int ecyc, output int emode, output bit esup, output string req);
        logic [7:0] v;
        logic [7:0] h1;
        int         rmw;
        h1 = h + 8'd1;
        ea = a; ex = x; ey = y; es = s; ewd = 8'h00;
        ewr = 1'b0; en = n; ez = z; ec = c;
        ecyc = 0; emode = 15; esup = 1'b1; req = "R10";
        rmw = -1;
        case (op)
            8'h07, 8'h47: begin rmw = 1; ecyc = 5; end
            8'h17, 8'h57: begin rmw = 2; ecyc = 6; end
            8'h0F, 8'h4F: begin rmw = 4; ecyc = 6; end
            8'h1F, 8'h5F: begin rmw = 5; ecyc = 7; end
            8'h1B, 8'h5B: begin rmw = 6; ecyc = 7; end
            8'h03, 8'h43: begin rmw = 7; ecyc = 8; end
            8'h13, 8'h53: begin rmw = 8; ecyc = 8; end
            default: ;
        endcase
        if (rmw >= 0) begin
            emode = rmw; ewr = 1'b1;
            if (op[6] == 1'b0) begin
                req = "R3";
                ewd = m << 1; ea = a | ewd; ec = m[7];
            end else begin
                req = "R4";
                ewd = m >> 1; ea = a ^ ewd; ec = m[0];
            end
            en = ea[7]; ez = (ea == 0);
        end else begin
            case (op)
                8'hAB, 8'hA7, 8'hB7, 8'hAF, 8'hBF, 8'hA3, 8'hB3: begin
                    req = "R1";
                    v = (op == 8'hAB) ? ((a | K) & m) : m;
                    ea = v; ex = v; en = v[7]; ez = (v == 0);
                    case (op)
                        8'hAB: begin emode = 0; ecyc = 2; end
                        8'hA7: begin emode = 1; ecyc = 3; end
                        8'hB7: begin emode = 3; ecyc = 4; end
                        8'hAF: begin emode = 4; ecyc = 4; end
                        8'hBF: begin emode = 6; ecyc = 4 + int'(pc); end
                        8'hA3: begin emode = 7; ecyc = 6; end
                        default: begin emode = 8; ecyc = 5 + int'(pc); end
                    endcase
                end
                8'hCB: begin
                    req = "R2"; emode = 0; ecyc = 2;
                    v = (a & x) - m; ex = v; en = v[7]; ez = (v == 0);
                    ec = ((a & x) >= m);
                end
                8'hBB: begin
                    req = "R5"; emode = 6; ecyc = 4 + int'(pc);
                    v = m & s; ea = v; ex = v; es = v; en = v[7]; ez = (v == 0);
                end
                8'h9E: begin req = "R6"; emode = 6; ecyc = 5; ewr = 1; ewd = x & h1; end
                8'h9C: begin req = "R6"; emode = 5; ecyc = 5; ewr = 1; ewd = y & h1; end
                8'h9F: begin req = "R6"; emode = 6; ecyc = 5; ewr = 1; ewd = a & x & h1; end
                8'h93: begin req = "R6"; emode = 8; ecyc = 6; ewr = 1; ewd = a & x & h1; end
                8'h9B: begin req = "R6"; emode = 6; ecyc = 5; ewr = 1; es = a & x; ewd = a & x & h1; end
                8'h8B: begin
                    req = "R7"; emode = 0; ecyc = 2;
                    v = (a | K) & x & m; ea = v; en = v[7]; ez = (v == 0);
                end
                default: esup = 1'b0;
            endcase
        end
    endfunction

    task automatic run_one(input logic [7:0] op, a, x, y, s, m, h,
                           input logic [2:0] nzc, input logic pc);
        logic [7:0] ea, ex, ey, es, ewd;
        logic ewr, en, ez, ec;
        int ecyc, emode, seen;
        bit esup;
        string req;
        model(op, a, x, y, s, m, h, nzc[2], nzc[1], nzc[0], pc,
              ea, ex, ey, es, ewd, ewr, en, ez, ec, ecyc, emode, esup, req);
        @(negedge clk);
        opcode = op; reg_a = a; reg_x = x; reg_y = y; reg_s = s;
        operand = m; addr_hi = h; page_cross = pc;
        {flag_n_in, flag_z_in, flag_c_in} = nzc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(a_out == ea, req, "a_out", a_out, ea);
        chk(x_out == ex, req, "x_out", x_out, ex);
        chk(y_out == ey, req, "y_out", y_out, ey);
        chk(s_out == es, req, "s_out", s_out, es);
        chk({flag_n, flag_z, flag_c} == {en, ez, ec}, req, "flags NZC",
            {flag_n, flag_z, flag_c}, {en, ez, ec});
        chk(int'(addr_mode) == emode, "R9", "addr_mode", addr_mode, emode);
        chk(unsupported == !esup, "R10", "unsupported pulse", unsupported, !esup);
        chk(!done && !mem_we, "R11", "done/we early", {done, mem_we}, 0);
        if (esup) begin
            seen = 0;
            for (int k = 1; k <= 12; k++) begin
                @(negedge clk);
                if (k == 1) chk(!unsupported, "R10", "no unsupported on supported op", unsupported, 0);
                if (done) begin
                    seen = k;
                    chk(mem_we == ewr, "R11", "mem_we in done cycle", mem_we, ewr);
                    if (ewr) chk(mem_wdata == ewd, req, "mem_wdata", mem_wdata, ewd);
                    break;
                end else begin
                    chk(!mem_we, "R11", "mem_we outside done", mem_we, 0);
                end
            end
            chk(seen == ecyc - 1, "R8", "edges from start to done", seen, ecyc - 1);
        end else begin
            chk(!busy, "R10", "busy after unsupported", busy, 0);
            @(negedge clk);
            chk(!unsupported && !done && !busy && !mem_we, "R10", "single pulse, no run",
                {unsupported, done, busy, mem_we}, 0);
        end
    endtask

    typedef struct {
        logic [7:0] a, x, y, s, m, h;
        logic [2:0] nzc;
    } vec_t;

    initial begin
        vec_t vs[4];
        int seen;
        vs[0] = '{8'h3C, 8'hF0, 8'h5A, 8'hFD, 8'h81, 8'h12, 3'b000};
        vs[1] = '{8'hFF, 8'h0F, 8'hA5, 8'h7F, 8'h0F, 8'hFF, 3'b111};
        vs[2] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'b010};
        vs[3] = '{8'h55, 8'h33, 8'hC3, 8'hFF, 8'hC0, 8'h7F, 3'b101};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state
        chk({a_out, x_out, y_out, s_out, mem_wdata} == '0, "R13", "data after reset",
            {a_out, x_out}, 0);
        chk({flag_n, flag_z, flag_c} == 3'b000, "R13", "flags after reset", {flag_n, flag_z, flag_c}, 0);
        chk(addr_mode == 4'd15, "R13", "addr_mode after reset", addr_mode, 15);
        chk(!busy && !done && !mem_we && !unsupported, "R13", "control after reset",
            {busy, done, mem_we, unsupported}, 0);

        for (int p = 0; p < 2; p++)
            for (int v = 0; v < 4; v++)
                for (int op = 0; op < 256; op++)
                    run_one(8'(op), vs[v].a, vs[v].x, vs[v].y, vs[v].s, vs[v].m,
                            vs[v].h, vs[v].nzc, p[0]);

        // R12: start while busy is ignored (SLO abs, 6 cycles)
        @(negedge clk);
        opcode = 8'h0F; reg_a = 8'h10; reg_x = 8'h00; reg_y = 8'h00; reg_s = 8'h00;
        operand = 8'h21; addr_hi = 8'h00; page_cross = 1'b0;
        {flag_n_in, flag_z_in, flag_c_in} = 3'b000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(a_out == 8'h52, "R12", "a_out before overlap", a_out, 8'h52);
        opcode = 8'hAB; reg_a = 8'hFF; operand = 8'hFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(a_out == 8'h52 && addr_mode == 4'd4, "R12", "a_out after ignored start", a_out, 8'h52);
        seen = 1;
        for (int k = 2; k <= 12; k++) begin
            @(negedge clk);
            if (done) begin
                seen = k;
                chk(mem_wdata == 8'h42 && mem_we, "R12", "write data after overlap", mem_wdata, 8'h42);
                break;
            end
        end
        chk(seen == 5, "R12", "count undisturbed", seen, 5);
        @(negedge clk);
        chk(!busy && !done, "R12", "idle after run", {busy, done}, 0);
        summary();
    end

endmodule